// File: doc/BRIEF.md
# Privileged Indirect Register Router

This block sits between a CPU's indirect register access port and one interrupt file holding per-identity pending and enable state. Each request carries a privilege level, a virtualization flag, a guest-file selector, a word-width flag, a register select code, write data and a write mask. The router decides whether the request is legal for this instance. It picks the interrupt file page that the request targets and decodes the select code into one of five access kinds. For the two word-array kinds it also computes a word index.

A legal request is presented to the interrupt file one cycle after it is accepted. The write mask is trimmed to the bits that the addressed register can hold. Read data coming back from the file is trimmed in the same way and returned to the CPU in that same cycle. A request that fails any check produces an error response and zero read data. Nothing is forwarded for it, so the file cannot change state. One parameter fixes the instance as either a machine-level file with a single page or a supervisor-level file with guest pages.

Top module: `irr_top`

## Requirements
- R1: With `MMODE`=1 a request is legal only when privilege is 2'b11 (machine) and the virtualization flag is 0; it targets page 0, and every other privilege/flag combination is an error.
- R2: With `MMODE`=0 only privilege 2'b01 (supervisor) is accepted; privilege 2'b00 or 2'b11 is an error, and a non-virtualized supervisor request targets page 0.
- R3: A virtualized supervisor request targets the page given by the guest-file selector; a selector of 0 or one not below `NUM_PAGES` is an error.
- R4: Select 8'h70 decodes to kind 0 (delivery), 8'h72 to kind 1 (threshold), 8'h74 to kind 2 (top interrupt), 8'h80..8'hBF to kind 3 (pending word, number = select − 8'h80) and 8'hC0..8'hFF to kind 4 (enable word, number = select − 8'hC0); any other select is an error.
- R5: In 64-bit mode (`req_xlen64`=1) an odd word number is an error and an even one is halved to form the word index; in 32-bit mode the word number is the index.
- R6: A word index not below `NUM_IDS`/32 (32-bit mode) or `NUM_IDS`/64 (64-bit mode) is an error.
- R7: An erroneous request gives `rsp_err`=1, `rsp_rdata`=0, `fwd_valid`=0 and `fwd_wmask`=0.
- R8: A request accepted at a clock edge shows its response (`rsp_valid`) and, if legal, its forwarded access (`fwd_valid`, page, kind, index, width flag, unchanged write data) after the next edge; with no request both stay low.
- R9: The forwarded write mask is the request mask, with bits 63:32 cleared in 32-bit mode; for kind 0 only bit 0 is kept, and for kind 1 only the low `ID_W` bits are kept. In 32-bit mode bits 63:32 of `rsp_rdata` are 0.
- R10: For kinds 3 and 4 with word index 0, bit 0 of the forwarded mask and bit 0 of `rsp_rdata` are 0; otherwise `rsp_rdata` equals `fwd_rdata` after the width trim of R9.
- R11: While `rst_n` is low, `rsp_valid`, `rsp_err` and `fwd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| req_virt | input | 1 | Request comes from a virtualized context |
| req_gsel | input | GSEL_W | Guest-file selector |
| req_xlen64 | input | 1 | 1 = 64-bit word mode, 0 = 32-bit |
| req_sel | input | 8 | Register select code |
| req_wdata | input | 64 | Write data |
| req_wmask | input | 64 | Write mask, all zero for a pure read |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was illegal |
| rsp_rdata | output | 64 | Read data, zero on error |
| fwd_valid | output | 1 | Legal access presented to the interrupt file |
| fwd_page | output | PAGE_W | Target page |
| fwd_kind | output | 3 | Access kind 0..4 |
| fwd_widx | output | 6 | Word index for kinds 3 and 4 |
| fwd_xlen64 | output | 1 | Word width of the access |
| fwd_wdata | output | 64 | Write data |
| fwd_wmask | output | 64 | Trimmed write mask |
| fwd_rdata | input | 64 | Read data returned by the interrupt file |

## Verification
The bench builds two instances side by side. The first is a supervisor instance with four pages and 256 identities, so the pending and enable arrays have eight 32-bit words or four 64-bit words. That makes page selection across guest pages, the index ceiling in both word modes and the odd-number rejection all reachable with small select codes. The second is a machine instance with one page and 64 identities. It covers the narrower legality rule, where any virtualized or lower-privilege request must fail.

// File: rtl/irr_pkg.sv
`timescale 1ns/1ps
package irr_pkg;
  typedef enum logic [2:0] {
    K_DELIV  = 3'd0,
    K_THRESH = 3'd1,
    K_TOP    = 3'd2,
    K_PEND   = 3'd3,
    K_ENAB   = 3'd4
  } kind_e;

  localparam logic [1:0] PRIV_USR = 2'b00;
  localparam logic [1:0] PRIV_SUP = 2'b01;
  localparam logic [1:0] PRIV_MCH = 2'b11;

  localparam int SEL_W   = 8;
  localparam int DATA_W  = 64;
  localparam int WIDX_W  = 6;
  localparam int BLK_LEN = 64;

  localparam logic [SEL_W-1:0] SEL_DELIV  = 8'h70;
  localparam logic [SEL_W-1:0] SEL_THRESH = 8'h72;
  localparam logic [SEL_W-1:0] SEL_TOP    = 8'h74;
  localparam logic [SEL_W-1:0] SEL_PBASE  = 8'h80;
  localparam logic [SEL_W-1:0] SEL_EBASE  = 8'hC0;

  // number of words an array of ids occupies at the chosen width
  function automatic int words_avail(input int num_ids, input logic x64);
    return x64 ? (num_ids / 64) : (num_ids / 32);
  endfunction

  function automatic logic in_block(input logic [SEL_W-1:0] sel,
                                    input logic [SEL_W-1:0] base);
    logic [SEL_W:0] s, b;
    s = {1'b0, sel};
    b = {1'b0, base};
    return (s >= b) && (s < b + (SEL_W+1)'(BLK_LEN));
  endfunction

  function automatic logic is_word_kind(input kind_e k);
    return (k == K_PEND) || (k == K_ENAB);
  endfunction
endpackage

// File: rtl/irr_page_sel.sv
`timescale 1ns/1ps
module irr_page_sel
  import irr_pkg::*;
#(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_PAGES = 4,
  parameter int GSEL_W    = 6,
  parameter int PAGE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic [GSEL_W-1:0] gsel,
  output logic              legal,
  output logic [PAGE_W-1:0] page
);
  always_comb begin
    legal = 1'b0;
    page  = '0;
    if (MMODE) begin
      legal = (priv == PRIV_MCH) && !virt;
    end else if (priv == PRIV_SUP) begin
      if (!virt) begin
        legal = 1'b1;
      end else if ((gsel != '0) && (int'(gsel) < NUM_PAGES)) begin
        legal = 1'b1;
        page  = gsel[PAGE_W-1:0];
      end
    end
  end

  AST_PAGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (int'(page) < NUM_PAGES));                          // R3
  AST_NONVIRT_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && !virt) |-> (page == '0));                           // R2
  AST_VIRT_GSEL_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && virt) |-> (gsel != '0));                            // R3
  AST_PRIV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (MMODE ? (priv == PRIV_MCH && !virt) : (priv == PRIV_SUP))); // R1
endmodule

// File: rtl/irr_sel_decode.sv
`timescale 1ns/1ps
module irr_sel_decode
  import irr_pkg::*;
#(
  parameter int NUM_IDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              x64,
  output logic              legal,
  output kind_e             kind,
  output logic [WIDX_W-1:0] widx
);
  logic              hit_pend, hit_enab;
  logic [WIDX_W-1:0] wnum;
  int                limit;

  assign hit_pend = in_block(sel, SEL_PBASE);
  assign hit_enab = in_block(sel, SEL_EBASE);
  assign limit    = words_avail(NUM_IDS, x64);

  always_comb begin
    legal = 1'b0;
    kind  = K_DELIV;
    widx  = '0;
    wnum  = '0;
    if (sel == SEL_DELIV) begin
      legal = 1'b1;
      kind  = K_DELIV;
    end else if (sel == SEL_THRESH) begin
      legal = 1'b1;
      kind  = K_THRESH;
    end else if (sel == SEL_TOP) begin
      legal = 1'b1;
      kind  = K_TOP;
    end else if (hit_pend || hit_enab) begin
      kind = hit_pend ? K_PEND : K_ENAB;
      wnum = hit_pend ? WIDX_W'(sel - SEL_PBASE) : WIDX_W'(sel - SEL_EBASE);
      widx = x64 ? (wnum >> 1) : wnum;
      legal = !(x64 && wnum[0]) && (int'(widx) < limit);
    end
  end

  AST_X64_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && x64 && is_word_kind(kind)) |-> !sel[0]);            // R5
  AST_IDX_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && is_word_kind(kind)) |-> (int'(widx) < words_avail(NUM_IDS, x64))); // R6
  AST_DELIV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && kind == K_DELIV) |-> (sel == SEL_DELIV));           // R4
endmodule

// File: rtl/irr_shape.sv
`timescale 1ns/1ps
module irr_shape
  import irr_pkg::*;
#(
  parameter int ID_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  kind_e             kind,
  input  logic              x64,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] mask_in,
  input  logic [DATA_W-1:0] rd_in,
  output logic [DATA_W-1:0] mask_out,
  output logic [DATA_W-1:0] rd_out
);
  localparam logic [DATA_W-1:0] ID_MASK = DATA_W'((64'd1 << ID_W) - 64'd1);

  function automatic logic [DATA_W-1:0] width_trim(input logic [DATA_W-1:0] v,
                                                   input logic w64);
    return w64 ? v : {32'b0, v[31:0]};
  endfunction

  function automatic logic [DATA_W-1:0] trim_mask(input logic [DATA_W-1:0] m,
                                                  input kind_e k, input logic w64,
                                                  input logic [WIDX_W-1:0] ix);
    logic [DATA_W-1:0] r;
    r = width_trim(m, w64);
    case (k)
      K_DELIV:  r = r & 64'd1;
      K_THRESH: r = r & ID_MASK;
      K_PEND, K_ENAB: if (ix == '0) r[0] = 1'b0;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] trim_rd(input logic [DATA_W-1:0] d,
                                                input kind_e k, input logic w64,
                                                input logic [WIDX_W-1:0] ix);
    logic [DATA_W-1:0] r;
    r = width_trim(d, w64);
    if (is_word_kind(k) && ix == '0) r[0] = 1'b0;
    return r;
  endfunction

  assign mask_out = act ? trim_mask(mask_in, kind, x64, widx) : '0;
  assign rd_out   = act ? trim_rd(rd_in, kind, x64, widx) : '0;

  AST_WORD0_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (is_word_kind(kind) && widx == '0) |-> (!mask_out[0] && !rd_out[0])); // R10
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !x64 |-> (mask_out[63:32] == '0 && rd_out[63:32] == '0));     // R9
  AST_DELIV_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_DELIV) |-> (mask_out[63:1] == '0));                // R9
endmodule

// File: rtl/irr_top.sv
`timescale 1ns/1ps
module irr_top
  import irr_pkg::*;
#(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_PAGES = 4,
  parameter int NUM_IDS   = 256,
  parameter int GSEL_W    = 6,
  parameter int ID_W      = 11,
  localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_priv,
  input  logic              req_virt,
  input  logic [GSEL_W-1:0] req_gsel,
  input  logic              req_xlen64,
  input  logic [7:0]        req_sel,
  input  logic [63:0]       req_wdata,
  input  logic [63:0]       req_wmask,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic              fwd_valid,
  output logic [PAGE_W-1:0] fwd_page,
  output logic [2:0]        fwd_kind,
  output logic [5:0]        fwd_widx,
  output logic              fwd_xlen64,
  output logic [63:0]       fwd_wdata,
  output logic [63:0]       fwd_wmask,
  input  logic [63:0]       fwd_rdata
);
  // decode-stage events, named for the assertions
  logic              page_ok, sel_ok, req_ok;
  logic [PAGE_W-1:0] d_page;
  kind_e             d_kind;
  logic [WIDX_W-1:0] d_widx;

  // registered access
  logic              s_valid, s_err, s_x64;
  logic [PAGE_W-1:0] s_page;
  kind_e             s_kind;
  logic [WIDX_W-1:0] s_widx;
  logic [63:0]       s_wdata, s_wmask;
  logic              s_act;

  irr_page_sel #(
    .MMODE(MMODE), .NUM_PAGES(NUM_PAGES), .GSEL_W(GSEL_W), .PAGE_W(PAGE_W)
  ) u_page (
    .clk(clk), .rst_n(rst_n), .priv(req_priv), .virt(req_virt),
    .gsel(req_gsel), .legal(page_ok), .page(d_page)
  );

  irr_sel_decode #(.NUM_IDS(NUM_IDS)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(req_sel), .x64(req_xlen64),
    .legal(sel_ok), .kind(d_kind), .widx(d_widx)
  );

  assign req_ok = page_ok && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_err   <= 1'b0;
      s_x64   <= 1'b0;
      s_page  <= '0;
      s_kind  <= K_DELIV;
      s_widx  <= '0;
      s_wdata <= '0;
      s_wmask <= '0;
    end else begin
      s_valid <= req_valid;
      s_err   <= req_valid && !req_ok;
      s_x64   <= req_xlen64;
      s_page  <= d_page;
      s_kind  <= d_kind;
      s_widx  <= d_widx;
      s_wdata <= req_wdata;
      s_wmask <= req_wmask;
    end
  end

  assign s_act = s_valid && !s_err;

  irr_shape #(.ID_W(ID_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .act(s_act), .kind(s_kind), .x64(s_x64),
    .widx(s_widx), .mask_in(s_wmask), .rd_in(fwd_rdata),
    .mask_out(fwd_wmask), .rd_out(rsp_rdata)
  );

  assign rsp_valid  = s_valid;
  assign rsp_err    = s_valid && s_err;
  assign fwd_valid  = s_act;
  assign fwd_page   = s_page;
  assign fwd_kind   = s_kind;
  assign fwd_widx   = s_widx;
  assign fwd_xlen64 = s_x64;
  assign fwd_wdata  = s_wdata;

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!fwd_valid && rsp_rdata == '0 && fwd_wmask == '0)); // R7
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);                                     // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !fwd_valid));                   // R8
  AST_BAD_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !page_ok) |=> rsp_err);                         // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !fwd_valid));                       // R11
endmodule

// File: tb/sim_irr_top.sv
`timescale 1ns/1ps
module sim_irr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_priv = 2'b00;
  logic        req_virt = 1'b0;
  logic [5:0]  req_gsel = '0;
  logic        req_xlen64 = 1'b0;
  logic [7:0]  req_sel = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_wmask = '0;

  localparam logic [63:0] FRD = 64'hA5A5_5A5A_C3C3_0F0F;
  localparam logic [63:0] WD  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] ONES = '1;

  logic        a_rv, a_re, a_fv, a_fx;
  logic [63:0] a_rd, a_fwd, a_fwm;
  logic [1:0]  a_pg;
  logic [2:0]  a_kd;
  logic [5:0]  a_ix;
  logic        b_rv, b_re, b_fv, b_fx;
  logic [63:0] b_rd, b_fwd, b_fwm;
  logic [0:0]  b_pg;
  logic [2:0]  b_kd;
  logic [5:0]  b_ix;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irr_top #(.MMODE(1'b0), .NUM_PAGES(4), .NUM_IDS(256), .GSEL_W(6), .ID_W(11)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .req_virt(req_virt), .req_gsel(req_gsel), .req_xlen64(req_xlen64),
    .req_sel(req_sel), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rsp_valid(a_rv), .rsp_err(a_re), .rsp_rdata(a_rd), .fwd_valid(a_fv),
    .fwd_page(a_pg), .fwd_kind(a_kd), .fwd_widx(a_ix), .fwd_xlen64(a_fx),
    .fwd_wdata(a_fwd), .fwd_wmask(a_fwm), .fwd_rdata(FRD)
  );

  irr_top #(.MMODE(1'b1), .NUM_PAGES(1), .NUM_IDS(64), .GSEL_W(6), .ID_W(11)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .req_virt(req_virt), .req_gsel(req_gsel), .req_xlen64(req_xlen64),
    .req_sel(req_sel), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rsp_valid(b_rv), .rsp_err(b_re), .rsp_rdata(b_rd), .fwd_valid(b_fv),
    .fwd_page(b_pg), .fwd_kind(b_kd), .fwd_widx(b_ix), .fwd_xlen64(b_fx),
    .fwd_wdata(b_fwd), .fwd_wmask(b_fwm), .fwd_rdata(FRD)
  );

  // {priv, virt, gsel, x64, sel, req#, err, page, kind, idx}
  localparam int NV = 17;
  localparam logic [33:0] VEC [NV] = '{
    {2'd1, 1'b0, 6'd0, 1'b0, 8'h70, 4'd4,  1'b0, 2'd0, 3'd0, 6'd0}, // R4 delivery
    {2'd1, 1'b0, 6'd0, 1'b0, 8'h72, 4'd4,  1'b0, 2'd0, 3'd1, 6'd0}, // R4 threshold
    {2'd1, 1'b0, 6'd0, 1'b1, 8'h74, 4'd4,  1'b0, 2'd0, 3'd2, 6'd0}, // R4 top, 64-bit
    {2'd1, 1'b1, 6'd3, 1'b0, 8'h83, 4'd3,  1'b0, 2'd3, 3'd3, 6'd3}, // R3 guest page 3
    {2'd1, 1'b1, 6'd1, 1'b0, 8'hC7, 4'd3,  1'b0, 2'd1, 3'd4, 6'd7}, // R3 guest page 1
    {2'd1, 1'b0, 6'd0, 1'b0, 8'h88, 4'd6,  1'b1, 2'd0, 3'd0, 6'd0}, // R6 idx 8 of 8
    {2'd1, 1'b0, 6'd0, 1'b1, 8'h86, 4'd5,  1'b0, 2'd0, 3'd3, 6'd3}, // R5 even halved
    {2'd1, 1'b0, 6'd0, 1'b1, 8'h85, 4'd5,  1'b1, 2'd0, 3'd0, 6'd0}, // R5 odd
    {2'd1, 1'b0, 6'd0, 1'b1, 8'hC8, 4'd6,  1'b1, 2'd0, 3'd0, 6'd0}, // R6 idx 4 of 4
    {2'd1, 1'b1, 6'd0, 1'b0, 8'h70, 4'd3,  1'b1, 2'd0, 3'd0, 6'd0}, // R3 selector 0
    {2'd1, 1'b1, 6'd4, 1'b0, 8'h70, 4'd3,  1'b1, 2'd0, 3'd0, 6'd0}, // R3 selector 4
    {2'd3, 1'b0, 6'd0, 1'b0, 8'h70, 4'd2,  1'b1, 2'd0, 3'd0, 6'd0}, // R2 machine priv
    {2'd0, 1'b0, 6'd0, 1'b0, 8'h70, 4'd2,  1'b1, 2'd0, 3'd0, 6'd0}, // R2 user priv
    {2'd1, 1'b0, 6'd0, 1'b0, 8'h71, 4'd4,  1'b1, 2'd0, 3'd0, 6'd0}, // R4 unknown
    {2'd1, 1'b0, 6'd0, 1'b1, 8'hC0, 4'd10, 1'b0, 2'd0, 3'd4, 6'd0}, // R10 64-bit word 0
    {2'd1, 1'b0, 6'd0, 1'b0, 8'hBF, 4'd6,  1'b1, 2'd0, 3'd0, 6'd0}, // R6 idx 63
    {2'd1, 1'b0, 6'd0, 1'b0, 8'h80, 4'd10, 1'b0, 2'd0, 3'd3, 6'd0}  // R10 32-bit word 0
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mask(input logic [2:0] k, input logic w,
                                           input logic [5:0] ix);
    logic [63:0] m;
    m = w ? ONES : {32'h0, 32'hFFFF_FFFF};
    if (k == 3'd0) m = 64'h1;
    else if (k == 3'd1) m = 64'h7FF;
    else if ((k == 3'd3 || k == 3'd4) && ix == 0) m = m & ~64'h1;
    return m;
  endfunction

  function automatic logic [63:0] exp_rd(input logic [2:0] k, input logic w,
                                         input logic [5:0] ix);
    logic [63:0] d;
    d = w ? FRD : {32'h0, FRD[31:0]};
    if ((k == 3'd3 || k == 3'd4) && ix == 0) d = d & ~64'h1;
    return d;
  endfunction

  task automatic drive(input logic [1:0] p, input logic v, input logic [5:0] g,
                       input logic w, input logic [7:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_priv = p; req_virt = v; req_gsel = g;
    req_xlen64 = w; req_sel = s; req_wdata = WD; req_wmask = ONES;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", {63'b0, a_rv}, 64'd0);
    check("R11", {63'b0, a_fv}, 64'd0);
    check("R11", {63'b0, b_rv | b_re | a_re}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle", {63'b0, a_rv | a_fv}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] e;
      string tg;
      e = VEC[i];
      tg = $sformatf("R%0d vec%0d", e[15:12], i);
      drive(e[33:32], e[31], e[30:25], e[24], e[23:16]);
      check({tg, " rsp_valid R8"}, {63'b0, a_rv}, 64'd1);
      check({tg, " err"}, {63'b0, a_re}, {63'b0, e[11]});
      if (e[11]) begin
        check({tg, " R7 no fwd"}, {63'b0, a_fv}, 64'd0);
        check({tg, " R7 rdata"}, a_rd, 64'd0);
        check({tg, " R7 mask"}, a_fwm, 64'd0);
      end else begin
        check({tg, " fwd_valid"}, {63'b0, a_fv}, 64'd1);
        check({tg, " page"}, {62'b0, a_pg}, {62'b0, e[10:9]});
        check({tg, " kind"}, {61'b0, a_kd}, {61'b0, e[8:6]});
        check({tg, " idx"}, {58'b0, a_ix}, {58'b0, e[5:0]});
        check({tg, " R8 width"}, {63'b0, a_fx}, {63'b0, e[24]});
        check({tg, " R8 wdata"}, a_fwd, WD);
        check({tg, " R9 mask"}, a_fwm, exp_mask(e[8:6], e[24], e[5:0]));
        check({tg, " R10 rdata"}, a_rd, exp_rd(e[8:6], e[24], e[5:0]));
      end
    end

    // request dropped: nothing follows on the next cycle
    @(negedge clk);
    check("R8 quiet after drop", {62'b0, a_rv, a_fv}, 64'd0);

    // machine instance: legal only for non-virtualized machine requests
    drive(2'd3, 1'b0, 6'd0, 1'b0, 8'h70);
    check("R1 machine ok", {62'b0, b_re, b_fv}, 64'd1);
    check("R1 page0", {63'b0, b_pg}, 64'd0);
    check("R1 kind", {61'b0, b_kd}, 64'd0);
    drive(2'd3, 1'b1, 6'd0, 1'b0, 8'h70);
    check("R1 virt rejected", {62'b0, b_re, b_fv}, 64'd2);
    check("R1 virt rdata", b_rd, 64'd0);
    drive(2'd1, 1'b0, 6'd0, 1'b0, 8'h70);
    check("R1 sup rejected", {62'b0, b_re, b_fv}, 64'd2);
    drive(2'd3, 1'b0, 6'd0, 1'b1, 8'hC2);
    check("R6 machine 64ids idx1", {62'b0, b_re, b_fv}, 64'd2);

    // reset in the middle of traffic clears the response
    @(negedge clk);
    req_valid = 1'b1; req_priv = 2'd1; req_sel = 8'h70; rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset with request", {62'b0, a_rv, a_fv}, 64'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule